// File: doc/BRIEF.md
# Open-Drain Line Direction Arbiter

This block joins host-side open-drain data lines to card-side open-drain data lines when neither side says which way data is flowing. Each line has two physical sides. For each side the block sees a sense input, and it drives two enables: one that pulls the side low and one that pushes it high for a short time. When both sides are idle they float high through resistors. The first side that falls becomes the master for that low pulse, and the block copies the low to the other side after a counted delay. When the master lets go, the block stops pulling the slave low and pushes the slave high for a fixed number of cycles, so the rising edge is fast. The block then returns to idle.

One channel serves one line. The top module builds `NUM_LINES` identical channels: one for the data line and one for each auxiliary line. Each sense input passes through its own synchronizer before edges are detected, and every delay is counted in system clock cycles. While the card interface is not enabled, every card side is held low and nothing from the host is passed on. Level shifting and current limiting belong to the analog circuits outside this block.

Top module: `lnb_bridge`

## Requirements
- R1: While reset is applied, and in the first cycle after reset with `card_en` low, every `card_pull_low` bit is 1 and every `host_pull_low`, `host_push_high` and `card_push_high` bit is 0. The first clock edge that sees `card_en` high releases the card side: `card_pull_low` reads 0 after that edge.
- R2: With `card_en` high and both sides of a line high, none of that line's four outputs is asserted.
- R3: Suppose a host side falls while its line is idle. The matching `card_pull_low` bit then rises on the (DELAY_CYC+SYNC_STAGES+1)-th clock edge after the host line goes low, and not before. With the defaults this is the 7th edge.
- R4: The same holds in the other direction. A card side that falls first sets the matching `host_pull_low` bit on the (DELAY_CYC+SYNC_STAGES+1)-th clock edge.
- R5: Once a side is master, edges on the slave side are ignored. If the slave side is still held low externally when the master releases, the low is not sent back to the master side, because only a fresh falling edge in idle can start a transfer.
- R6: Suppose the master side returns high while the slave is being driven. The slave's pull-low drops on the (SYNC_STAGES+1)-th clock edge after the release. On that same edge the slave's push-high output rises, and it stays high for exactly PULSE_CYC cycles. Pull-low and push-high are never both active on one side.
- R7: If both sides of an idle line are seen falling in the same cycle, the host side wins. Only `card_pull_low` is asserted for that line, and the two pull-low outputs of a line are never active together.
- R8: One cycle after `card_en` is sampled low, every `card_pull_low` bit is 1 and every other output is 0, whatever state the channels were in. A host line that is still low when `card_en` returns high is not forwarded.
- R9: A host low pulse that ends before the delay has run out causes no card-side drive and no push pulse. With the defaults, a pulse of DELAY_CYC cycles or fewer is such a pulse.
- R10: Channels are independent. Activity on one line never changes the outputs of another line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all delays are counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_en | input | 1 | High while the card interface is active; low holds every card side low |
| host_sense | input | NUM_LINES | Level sensed on each host-side line (asynchronous) |
| card_sense | input | NUM_LINES | Level sensed on each card-side line (asynchronous) |
| host_pull_low | output | NUM_LINES | Pull the host-side line low |
| host_push_high | output | NUM_LINES | Short active pull-up pulse on the host-side line |
| card_pull_low | output | NUM_LINES | Pull the card-side line low (also the inactive hold) |
| card_push_high | output | NUM_LINES | Short active pull-up pulse on the card-side line |

## Verification
Some properties are checked on every cycle. The two sides of a line are never both pulled low. Pull-low and push-high never fight on one side. Every push pulse follows a slave drive and lasts exactly the configured length unless the interface is disabled partway through. A disabled interface always forces the hold pattern one cycle later. Other behaviour can only be shown by the bench's scenarios:
- the exact edge-to-drive latency in each direction;
- the host-wins tie;
- a short glitch that is swallowed;
- a slave side still held low after release that is not sent back;
- a host line left low across a disable that is not forwarded.

// File: rtl/lnb_pkg.sv
package lnb_pkg;

    // Channel states. HOLD is the inactive state that keeps the card side low.
    typedef enum logic [2:0] {
        ST_HOLD      = 3'd0,
        ST_IDLE      = 3'd1,
        ST_HOST_WAIT = 3'd2,
        ST_HOST_LEAD = 3'd3,
        ST_CARD_WAIT = 3'd4,
        ST_CARD_LEAD = 3'd5,
        ST_KICK_CARD = 3'd6,
        ST_KICK_HOST = 3'd7
    } lnb_state_e;

endpackage

// File: rtl/lnb_sync.sv
module lnb_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef logic [STAGES-1:0][WIDTH-1:0] chain_t;

    chain_t chain_d;
    chain_t chain_q;

    // Shift the raw level one stage per clock.
    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/lnb_channel.sv
module lnb_channel
    import lnb_pkg::*;
#(
    parameter int DELAY_CYC = 4,
    parameter int PULSE_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic host_s,
    input  logic card_s,
    output logic host_pull_low,
    output logic host_push_high,
    output logic card_pull_low,
    output logic card_push_high
);

    localparam int CNT_MAX = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] DLY_LOAD = CNT_W'(DELAY_CYC - 1);
    localparam logic [CNT_W-1:0] PLS_LOAD = CNT_W'(PULSE_CYC - 1);

    typedef struct packed {
        lnb_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             h_prev;
        logic             c_prev;
    } chan_t;

    // The card side is held low in reset, so its last seen level starts low.
    localparam chan_t CHAN_RST = '{st: ST_HOLD, cnt: '0, h_prev: 1'b1, c_prev: 1'b0};

    chan_t r_d;
    chan_t r_q;
    logic  host_fall;
    logic  card_fall;
    logic  cnt_zero;

    always_comb begin
        r_d        = r_q;
        r_d.h_prev = host_s;
        r_d.c_prev = card_s;
        host_fall  = r_q.h_prev & ~host_s;
        card_fall  = r_q.c_prev & ~card_s;
        cnt_zero   = (r_q.cnt == '0);

        if (!enable) begin
            r_d.st  = ST_HOLD;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_HOLD: begin
                    r_d.st = ST_IDLE;
                end
                ST_IDLE: begin
                    // Host side is checked first: it wins a same-cycle tie.
                    if (host_fall) begin
                        r_d.st  = ST_HOST_WAIT;
                        r_d.cnt = DLY_LOAD;
                    end else if (card_fall) begin
                        r_d.st  = ST_CARD_WAIT;
                        r_d.cnt = DLY_LOAD;
                    end
                end
                ST_HOST_WAIT: begin
                    if (host_s) begin
                        r_d.st = ST_IDLE;
                    end else if (cnt_zero) begin
                        r_d.st = ST_HOST_LEAD;
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
                ST_HOST_LEAD: begin
                    if (host_s) begin
                        r_d.st  = ST_KICK_CARD;
                        r_d.cnt = PLS_LOAD;
                    end
                end
                ST_CARD_WAIT: begin
                    if (card_s) begin
                        r_d.st = ST_IDLE;
                    end else if (cnt_zero) begin
                        r_d.st = ST_CARD_LEAD;
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
                ST_CARD_LEAD: begin
                    if (card_s) begin
                        r_d.st  = ST_KICK_HOST;
                        r_d.cnt = PLS_LOAD;
                    end
                end
                ST_KICK_CARD, ST_KICK_HOST: begin
                    if (cnt_zero) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
                default: begin
                    r_d.st = ST_HOLD;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= CHAN_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        host_pull_low  = (r_q.st == ST_CARD_LEAD);
        host_push_high = (r_q.st == ST_KICK_HOST);
        card_pull_low  = (r_q.st == ST_HOST_LEAD) || (r_q.st == ST_HOLD);
        card_push_high = (r_q.st == ST_KICK_CARD);
    end

endmodule

// File: rtl/lnb_bridge.sv
module lnb_bridge #(
    parameter int NUM_LINES   = 3,
    parameter int SYNC_STAGES = 2,
    parameter int DELAY_CYC   = 4,
    parameter int PULSE_CYC   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 card_en,
    input  logic [NUM_LINES-1:0] host_sense,
    input  logic [NUM_LINES-1:0] card_sense,
    output logic [NUM_LINES-1:0] host_pull_low,
    output logic [NUM_LINES-1:0] host_push_high,
    output logic [NUM_LINES-1:0] card_pull_low,
    output logic [NUM_LINES-1:0] card_push_high
);

    localparam logic [NUM_LINES-1:0] HOST_IDLE = '1;
    localparam logic [NUM_LINES-1:0] CARD_IDLE = '0;

    logic [NUM_LINES-1:0] host_s;
    logic [NUM_LINES-1:0] card_s;

    lnb_sync #(
        .WIDTH   (NUM_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (HOST_IDLE)
    ) i_host_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (host_sense),
        .sync_out (host_s)
    );

    lnb_sync #(
        .WIDTH   (NUM_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CARD_IDLE)
    ) i_card_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (card_sense),
        .sync_out (card_s)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        lnb_channel #(
            .DELAY_CYC (DELAY_CYC),
            .PULSE_CYC (PULSE_CYC)
        ) i_channel (
            .clk            (clk),
            .rst_n          (rst_n),
            .enable         (card_en),
            .host_s         (host_s[i]),
            .card_s         (card_s[i]),
            .host_pull_low  (host_pull_low[i]),
            .host_push_high (host_push_high[i]),
            .card_pull_low  (card_pull_low[i]),
            .card_push_high (card_push_high[i])
        );
    end

endmodule

// File: rtl/lnb_bridge_chk.sv
module lnb_bridge_chk #(
    parameter int NUM_LINES = 3,
    parameter int PULSE_CYC = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 card_en,
    input logic [NUM_LINES-1:0] host_pull_low,
    input logic [NUM_LINES-1:0] host_push_high,
    input logic [NUM_LINES-1:0] card_pull_low,
    input logic [NUM_LINES-1:0] card_push_high
);

    localparam int               RUN_W   = $clog2(PULSE_CYC + 2);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(PULSE_CYC + 1);

    assert_hold_pattern_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !card_en |=> (card_pull_low == '1 && host_pull_low == '0 &&
                      host_push_high == '0 && card_push_high == '0));

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_ln
        logic [RUN_W-1:0] hrun_q;
        logic [RUN_W-1:0] crun_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hrun_q <= '0;
                crun_q <= '0;
            end else begin
                hrun_q <= !host_push_high[i] ? '0 : (hrun_q == RUN_TOP ? hrun_q : hrun_q + 1'b1);
                crun_q <= !card_push_high[i] ? '0 : (crun_q == RUN_TOP ? crun_q : crun_q + 1'b1);
            end
        end

        assert_single_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(host_pull_low[i] && card_pull_low[i]));

        assert_no_fight_host_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(host_pull_low[i] && host_push_high[i]));

        assert_no_fight_card_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(card_pull_low[i] && card_push_high[i]));

        assert_card_kick_after_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(card_push_high[i]) |-> $past(card_pull_low[i]));

        assert_host_kick_after_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(host_push_high[i]) |-> $past(host_pull_low[i]));

        assert_card_kick_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(card_push_high[i]) && $past(card_en)) |-> (int'(crun_q) == PULSE_CYC));

        assert_host_kick_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(host_push_high[i]) && $past(card_en)) |-> (int'(hrun_q) == PULSE_CYC));
    end

endmodule

bind lnb_bridge lnb_bridge_chk #(
    .NUM_LINES (NUM_LINES),
    .PULSE_CYC (PULSE_CYC)
) i_lnb_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .card_en        (card_en),
    .host_pull_low  (host_pull_low),
    .host_push_high (host_push_high),
    .card_pull_low  (card_pull_low),
    .card_push_high (card_push_high)
);

// File: tb/test_lnb_bridge.sv
module test_lnb_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 3;
    localparam int SYNC       = 2;
    localparam int DLY        = 4;
    localparam int PLS        = 10;
    localparam int WATCHDOG   = 200000;
    localparam int NVEC       = 11;

    // {card_en, host_ext_low[2:0], card_ext_low[2:0], exp host_pull_low, exp card_pull_low}
    localparam logic [12:0] VECS [0:NVEC-1] = '{
        13'b1_000_000_000_000,  // all idle
        13'b1_001_000_000_001,  // host line 0 leads
        13'b1_001_010_010_001,  // card line 1 leads, line 0 unchanged
        13'b1_001_011_010_001,  // card also pulls line 0: ignored
        13'b1_000_001_000_000,  // host releases, card still low: not sent back
        13'b1_000_000_000_000,  // idle again
        13'b1_100_000_000_100,  // host line 2 leads
        13'b0_100_000_000_111,  // disable: hold pattern
        13'b1_100_000_000_000,  // enable with host still low: not forwarded
        13'b1_000_100_100_000,  // fresh card fall on line 2
        13'b1_000_000_000_000   // idle
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_en = 1'b0;
    logic [NL-1:0] host_ext_low = '0;
    logic [NL-1:0] card_ext_low = '0;
    logic [NL-1:0] host_sense;
    logic [NL-1:0] card_sense;
    logic [NL-1:0] host_pull_low;
    logic [NL-1:0] host_push_high;
    logic [NL-1:0] card_pull_low;
    logic [NL-1:0] card_push_high;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Open-drain wires: low when anyone pulls.
    assign host_sense = ~(host_ext_low | host_pull_low);
    assign card_sense = ~(card_ext_low | card_pull_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    lnb_bridge #(
        .NUM_LINES   (NL),
        .SYNC_STAGES (SYNC),
        .DELAY_CYC   (DLY),
        .PULSE_CYC   (PLS)
    ) i_lnb_bridge (
        .clk            (clk),
        .rst_n          (rst_n),
        .card_en        (card_en),
        .host_sense     (host_sense),
        .card_sense     (card_sense),
        .host_pull_low  (host_pull_low),
        .host_push_high (host_push_high),
        .card_pull_low  (card_pull_low),
        .card_push_high (card_push_high)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string vtag(input int v);
        case (v)
            1, 6:    return "R3";
            2, 9:    return "R4";
            3, 4:    return "R5";
            7, 8:    return "R8";
            default: return "R2";
        endcase
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        bit seen;

        // R1: reset and hold
        step(5);
        check("R1", "card hold in reset", 32'(card_pull_low), 32'h7);
        rst_n = 1'b1;
        step(1);
        check("R1", "card hold after reset", 32'(card_pull_low), 32'h7);
        check("R1", "host side quiet", 32'({host_pull_low, host_push_high, card_push_high}), 0);
        card_en = 1'b1;
        step(1);
        check("R1", "card released", 32'(card_pull_low), 0);
        step(10);

        // Table of steady states
        for (int v = 0; v < NVEC; v++) begin
            card_en      = VECS[v][12];
            host_ext_low = VECS[v][11:9];
            card_ext_low = VECS[v][8:6];
            step(40);
            check(vtag(v), "pull-low pattern",
                  32'({host_pull_low, card_pull_low}), 32'(VECS[v][5:0]));
            check(vtag(v), "no push at rest",
                  32'({host_push_high, card_push_high}), 0);
        end

        // R3 latency host -> card, then R6 release
        host_ext_low[0] = 1'b1;
        step(DLY + SYNC);
        check("R3", "card not yet driven", 32'(card_pull_low[0]), 0);
        step(1);
        check("R3", "card driven at delay", 32'(card_pull_low[0]), 1);
        check("R10", "other lines untouched",
              32'({card_pull_low[2:1], host_pull_low}), 0);
        step(20);
        host_ext_low[0] = 1'b0;
        step(SYNC);
        check("R6", "card still held before release seen", 32'(card_pull_low[0]), 1);
        step(1);
        check("R6", "card pull-low dropped", 32'(card_pull_low[0]), 0);
        check("R6", "card push started", 32'(card_push_high[0]), 1);
        n = 0;
        while (card_push_high[0] && n < 100) begin
            n++;
            step(1);
        end
        check("R6", "card push length", 32'(n), 32'(PLS));
        check("R6", "line idle after push",
              32'({host_pull_low, host_push_high, card_pull_low, card_push_high}), 0);
        step(5);

        // R4 latency card -> host, then release
        card_ext_low[1] = 1'b1;
        step(DLY + SYNC);
        check("R4", "host not yet driven", 32'(host_pull_low[1]), 0);
        step(1);
        check("R4", "host driven at delay", 32'(host_pull_low[1]), 1);
        step(20);
        card_ext_low[1] = 1'b0;
        step(SYNC + 1);
        check("R6", "host pull-low dropped", 32'(host_pull_low[1]), 0);
        n = 0;
        while (host_push_high[1] && n < 100) begin
            n++;
            step(1);
        end
        check("R6", "host push length", 32'(n), 32'(PLS));
        step(5);

        // R7 same-cycle tie on line 2
        host_ext_low[2] = 1'b1;
        card_ext_low[2] = 1'b1;
        step(20);
        check("R7", "host wins tie", 32'({host_pull_low[2], card_pull_low[2]}), 32'h1);
        host_ext_low[2] = 1'b0;
        card_ext_low[2] = 1'b0;
        step(30);
        check("R7", "line 2 idle after tie",
              32'({host_pull_low, host_push_high, card_pull_low, card_push_high}), 0);

        // R9 short glitch swallowed
        seen = 1'b0;
        host_ext_low[0] = 1'b1;
        step(2);
        host_ext_low[0] = 1'b0;
        for (int k = 0; k < 25; k++) begin
            if (card_pull_low[0] || card_push_high[0]) seen = 1'b1;
            step(1);
        end
        check("R9", "glitch not forwarded", 32'(seen), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule